// File: doc/BRIEF.md
# Contiguous Superpage Bundle Detector

This block sits on the fill path of a set-associative translation cache that holds small pages and superpages in one array. When the page walker returns a 64-byte page-table line, the block receives all eight 8-byte translations in it, the slot of the translation that missed, and the upper bits of the virtual superpage number that the line covers. From these it works out which superpages in the line can share one cache entry with the requested superpage. The result is a bundle: an aligned base virtual superpage number, the matching physical base frame, a presence bitmap, the permissions and a single dirty flag.

A slot joins the bundle only if it meets all of these conditions:
- it is a valid superpage whose access bit is set;
- its permissions equal those of the requested slot;
- its physical frame is offset from the requested frame by exactly the slot distance;
- it lies in the same aligned group as the requested slot.

Slots that fail any condition leave a hole in the bitmap. The decision logic is combinational. One register stage presents the bundle to the fill writer one cycle after the line arrives.

Top module: `superpage_coalescer`

## Requirements
- R1: When the requested slot is a valid, accessed superpage, `bnd_ok` is 1 and the bitmap bit for that slot is set. Otherwise `bnd_ok` is 0 and the bitmap and dirty flag are all zero.
- R2: Each bundle covers GRP slots (default 4) starting at the requested slot index with its low log2(GRP) bits cleared. Bitmap bit k stands for slot base+k. Slots outside that group never appear.
- R3: Within the group, slot j is marked only if its frame field equals the requested frame plus (j minus requested slot), modulo 2^FRAME_W. Otherwise its bit is 0, leaving a hole.
- R4: A slot is marked only if its permission field (translation bits 7:4) is identical to that of the requested slot.
- R5: A slot is marked only if its access bit (translation bit 1) is 1.
- R6: A slot whose valid bit (bit 0) is 0, or whose size bit (bit 3, 1 = superpage) is 0, is never marked. The frame field occupies bits 16 upward.
- R7: `bnd_dirty` is 1 exactly when every marked slot has its dirty bit (bit 2) set. Unmarked slots have no effect on it.
- R8: When `bnd_ok` is 1, `bnd_vfn` is {line tag, group base slot} with its low log2(GRP) bits zero, `bnd_pfn` is the requested frame minus the requested slot's offset in the group, and `bnd_perm` is the requested slot's permissions.
- R9: `bnd_valid` is 0 after reset and is 1 in the cycle after each cycle with `line_valid` high, else 0. Bundle fields hold their value while `line_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | A page-table line is presented this cycle |
| line_data | input | SLOTS*64 | Eight translations, slot i at bits 64*i upward |
| req_slot | input | log2(SLOTS) | Slot of the translation that missed |
| line_vtag | input | VTAG_W | Virtual superpage number bits above the slot index |
| bnd_valid | output | 1 | Bundle result present |
| bnd_ok | output | 1 | Requested slot was eligible |
| bnd_map | output | GRP | Presence bitmap relative to the bundle base |
| bnd_vfn | output | VTAG_W+log2(SLOTS) | Aligned base virtual superpage number |
| bnd_pfn | output | FRAME_W | Physical frame of the bundle base |
| bnd_perm | output | 4 | Permissions of the bundle |
| bnd_dirty | output | 1 | All members dirty |

## Verification
The first stimulus is a fully contiguous line. It shows that alignment alone limits the bundle, because eligible slots outside the group must stay clear. The next lines each break one member in a distinct way: a shifted frame, different permissions, a cleared access bit, a small page, or an invalid entry. Each of these must give a hole at exactly that bit, which separates the individual join conditions from one another. Further lines clear a dirty bit on a member and on a non-member, and make the requested slot itself ineligible, to separate dirty merging from gating. A set of generated lines with randomly spread defects, fed back to back, covers the group positions and confirms that one result per cycle leaves the pipeline in order.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int PTE_W     = 64;
  localparam int PERM_W    = 4;
  localparam int B_VALID   = 0;
  localparam int B_ACCESS  = 1;
  localparam int B_DIRTY   = 2;
  localparam int B_HUGE    = 3;
  localparam int B_PERM    = 4;
  localparam int B_FRAME   = 16;
endpackage

// File: rtl/spc_slot_decode.sv
module spc_slot_decode
  import spc_pkg::*;
#(
  parameter int FRAME_W = 28
) (
  input  logic [PTE_W-1:0]   pte,
  output logic               f_valid,
  output logic               f_access,
  output logic               f_dirty,
  output logic               f_huge,
  output logic [PERM_W-1:0]  f_perm,
  output logic [FRAME_W-1:0] f_frame
);
  always_comb begin
    f_valid  = pte[B_VALID];
    f_access = pte[B_ACCESS];
    f_dirty  = pte[B_DIRTY];
    f_huge   = pte[B_HUGE];
    f_perm   = pte[B_PERM +: PERM_W];
    f_frame  = pte[B_FRAME +: FRAME_W];
  end
endmodule

// File: rtl/spc_slot_match.sv
module spc_slot_match
  import spc_pkg::*;
#(
  parameter int SLOT_ID = 0,
  parameter int SLOTS   = 8,
  parameter int GRP     = 4,
  parameter int FRAME_W = 28
) (
  input  logic                     s_valid,
  input  logic                     s_access,
  input  logic                     s_huge,
  input  logic [PERM_W-1:0]        s_perm,
  input  logic [FRAME_W-1:0]       s_frame,
  input  logic [$clog2(SLOTS)-1:0] req_slot,
  input  logic [PERM_W-1:0]        req_perm,
  input  logic [FRAME_W-1:0]       req_frame,
  output logic                     member
);
  localparam int IDX_W  = $clog2(SLOTS);
  localparam int GRP_LG = $clog2(GRP);

  logic [FRAME_W-1:0] want_frame;
  logic               same_grp;
  logic               attr_ok;

  always_comb begin
    want_frame = req_frame - FRAME_W'(req_slot) + FRAME_W'(SLOT_ID);
    same_grp   = (IDX_W'(SLOT_ID) >> GRP_LG) == (req_slot >> GRP_LG);
    attr_ok    = s_valid & s_huge & s_access & (s_perm == req_perm);
    member     = attr_ok & same_grp & (s_frame == want_frame);
  end
endmodule

// File: rtl/spc_merge.sv
module spc_merge #(
  parameter int SLOTS = 8,
  parameter int GRP   = 4
) (
  input  logic [SLOTS-1:0]         member,
  input  logic [SLOTS-1:0]         dirty,
  input  logic [$clog2(SLOTS)-1:0] req_slot,
  output logic                     req_ok,
  output logic [GRP-1:0]           map,
  output logic                     all_dirty
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [IDX_W-1:0] grp_base;

  always_comb begin
    grp_base  = req_slot & ~IDX_W'(GRP - 1);
    req_ok    = member[req_slot];
    map       = '0;
    all_dirty = req_ok;
    for (int k = 0; k < GRP; k++) begin
      map[k] = req_ok & member[grp_base | IDX_W'(k)];
    end
    for (int j = 0; j < SLOTS; j++) begin
      if (member[j] && !dirty[j]) all_dirty = 1'b0;
    end
  end
endmodule

// File: rtl/superpage_coalescer.sv
module superpage_coalescer
  import spc_pkg::*;
#(
  parameter int SLOTS   = 8,
  parameter int GRP     = 4,
  parameter int FRAME_W = 28,
  parameter int VTAG_W  = 30
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           line_valid,
  input  logic [SLOTS*64-1:0]            line_data,
  input  logic [$clog2(SLOTS)-1:0]       req_slot,
  input  logic [VTAG_W-1:0]              line_vtag,
  output logic                           bnd_valid,
  output logic                           bnd_ok,
  output logic [GRP-1:0]                 bnd_map,
  output logic [VTAG_W+$clog2(SLOTS)-1:0] bnd_vfn,
  output logic [FRAME_W-1:0]             bnd_pfn,
  output logic [3:0]                     bnd_perm,
  output logic                           bnd_dirty
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int VFN_W = VTAG_W + IDX_W;

  logic [SLOTS-1:0]   d_valid, d_access, d_dirty, d_huge, d_member;
  logic [PERM_W-1:0]  d_perm  [SLOTS];
  logic [FRAME_W-1:0] d_frame [SLOTS];
  logic [PERM_W-1:0]  req_perm;
  logic [FRAME_W-1:0] req_frame;

  assign req_perm  = d_perm[req_slot];
  assign req_frame = d_frame[req_slot];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    spc_slot_decode #(.FRAME_W(FRAME_W)) u_dec (
      .pte      (line_data[i*PTE_W +: PTE_W]),
      .f_valid  (d_valid[i]),
      .f_access (d_access[i]),
      .f_dirty  (d_dirty[i]),
      .f_huge   (d_huge[i]),
      .f_perm   (d_perm[i]),
      .f_frame  (d_frame[i])
    );
    spc_slot_match #(.SLOT_ID(i), .SLOTS(SLOTS), .GRP(GRP), .FRAME_W(FRAME_W)) u_match (
      .s_valid   (d_valid[i]),
      .s_access  (d_access[i]),
      .s_huge    (d_huge[i]),
      .s_perm    (d_perm[i]),
      .s_frame   (d_frame[i]),
      .req_slot  (req_slot),
      .req_perm  (req_perm),
      .req_frame (req_frame),
      .member    (d_member[i])
    );
  end

  logic           c_ok, c_dirty;
  logic [GRP-1:0] c_map;

  spc_merge #(.SLOTS(SLOTS), .GRP(GRP)) u_merge (
    .member    (d_member),
    .dirty     (d_dirty),
    .req_slot  (req_slot),
    .req_ok    (c_ok),
    .map       (c_map),
    .all_dirty (c_dirty)
  );

  logic [IDX_W-1:0]   grp_off;
  logic [VFN_W-1:0]   c_vfn;
  logic [FRAME_W-1:0] c_pfn;

  always_comb begin
    grp_off = req_slot & IDX_W'(GRP - 1);
    c_vfn   = {line_vtag, req_slot & ~IDX_W'(GRP - 1)};
    c_pfn   = req_frame - FRAME_W'(grp_off);
  end

  // next-state
  logic               valid_d, ok_d, dirty_d;
  logic [GRP-1:0]     map_d;
  logic [VFN_W-1:0]   vfn_d;
  logic [FRAME_W-1:0] pfn_d;
  logic [3:0]         perm_d;

  always_comb begin
    valid_d = line_valid;
    ok_d    = bnd_ok;
    dirty_d = bnd_dirty;
    map_d   = bnd_map;
    vfn_d   = bnd_vfn;
    pfn_d   = bnd_pfn;
    perm_d  = bnd_perm;
    if (line_valid) begin
      ok_d    = c_ok;
      dirty_d = c_dirty;
      map_d   = c_map;
      vfn_d   = c_vfn;
      pfn_d   = c_pfn;
      perm_d  = req_perm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_valid <= 1'b0;
      bnd_ok    <= 1'b0;
      bnd_dirty <= 1'b0;
      bnd_map   <= '0;
      bnd_vfn   <= '0;
      bnd_pfn   <= '0;
      bnd_perm  <= '0;
    end else begin
      bnd_valid <= valid_d;
      bnd_ok    <= ok_d;
      bnd_dirty <= dirty_d;
      bnd_map   <= map_d;
      bnd_vfn   <= vfn_d;
      bnd_pfn   <= pfn_d;
      bnd_perm  <= perm_d;
    end
  end
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
  parameter int SLOTS  = 8,
  parameter int GRP    = 4,
  parameter int VTAG_W = 30
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           line_valid,
  input logic [$clog2(SLOTS)-1:0]       req_slot,
  input logic                           bnd_valid,
  input logic                           bnd_ok,
  input logic [GRP-1:0]                 bnd_map,
  input logic [VTAG_W+$clog2(SLOTS)-1:0] bnd_vfn,
  input logic                           bnd_dirty
);
  localparam int GRP_LG = $clog2(GRP);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> bnd_valid);
  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> !bnd_valid);
  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> $stable(bnd_map));
  // R1
  reject_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && !bnd_ok) |-> (bnd_map == '0 && !bnd_dirty));
  // R1
  req_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> (!bnd_ok || bnd_map[$past(req_slot[GRP_LG-1:0])]));
  // R8
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && bnd_ok) |-> (bnd_vfn[GRP_LG-1:0] == '0));
endmodule

bind superpage_coalescer spc_chk #(.SLOTS(SLOTS), .GRP(GRP), .VTAG_W(VTAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_valid (line_valid),
  .req_slot   (req_slot),
  .bnd_valid  (bnd_valid),
  .bnd_ok     (bnd_ok),
  .bnd_map    (bnd_map),
  .bnd_vfn    (bnd_vfn),
  .bnd_dirty  (bnd_dirty)
);

// File: tb/superpage_coalescer_test.sv
module superpage_coalescer_test;
  localparam int SLOTS = 8, GRP = 4, FRAME_W = 28, VTAG_W = 30;

  typedef struct packed {
    logic        ok;
    logic [3:0]  map;
    logic [32:0] vfn;
    logic [27:0] pfn;
    logic [3:0]  perm;
    logic        dirty;
    logic [7:0]  tag;
  } exp_t;

  logic clk = 0, rst_n = 0, line_valid = 0;
  logic [511:0] line_data = '0;
  logic [2:0]   req_slot = '0;
  logic [29:0]  line_vtag = '0;
  logic         bnd_valid, bnd_ok, bnd_dirty;
  logic [3:0]   bnd_map, bnd_perm;
  logic [32:0]  bnd_vfn;
  logic [27:0]  bnd_pfn;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  exp_t last_e;
  logic [511:0] ln;

  always #2.5 clk = ~clk;

  superpage_coalescer #(.SLOTS(SLOTS), .GRP(GRP), .FRAME_W(FRAME_W), .VTAG_W(VTAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
    .req_slot(req_slot), .line_vtag(line_vtag), .bnd_valid(bnd_valid), .bnd_ok(bnd_ok),
    .bnd_map(bnd_map), .bnd_vfn(bnd_vfn), .bnd_pfn(bnd_pfn), .bnd_perm(bnd_perm),
    .bnd_dirty(bnd_dirty));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  function automatic logic [63:0] mk(bit v, bit a, bit d, bit h, logic [3:0] perm, logic [27:0] fr);
    return {20'h0, fr, 8'h0, perm, h, d, a, v};
  endfunction

  function automatic logic [511:0] full_line(logic [27:0] f0, logic [3:0] perm);
    logic [511:0] l;
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = mk(1, 1, 1, 1, perm, f0 + 28'(i));
    return l;
  endfunction

  function automatic exp_t model(logic [511:0] l, int req, logic [29:0] tag, logic [7:0] id);
    exp_t e;
    logic [63:0] r, s;
    int g0;
    r = l[req*64 +: 64];
    g0 = req - (req % 4);
    e = '0;
    e.tag = id;
    e.ok = r[0] & r[1] & r[3];
    e.vfn = {tag, 3'(g0)};
    e.pfn = r[43:16] - 28'(req % 4);
    e.perm = r[7:4];
    e.dirty = e.ok;
    if (e.ok) begin
      for (int k = 0; k < 4; k++) begin
        s = l[(g0 + k)*64 +: 64];
        if (s[0] && s[1] && s[3] && s[7:4] == r[7:4] && s[43:16] == 28'(r[43:16] + 28'(g0 + k) - 28'(req))) begin
          e.map[k] = 1'b1;
          if (!s[2]) e.dirty = 1'b0;
        end
      end
    end
    return e;
  endfunction

  task automatic send(input logic [511:0] l, input int req, input logic [29:0] tag, input logic [7:0] id);
    @(negedge clk);
    line_valid = 1;
    line_data  = l;
    req_slot   = 3'(req);
    line_vtag  = tag;
    q.push_back(model(l, req, tag, id));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_valid = 0;
      line_data = '0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && bnd_valid) begin
      exp_t e;
      if (q.size() == 0) begin
        chk("R9 unexpected result", 1, 0);
      end else begin
        e = q.pop_front();
        last_e = e;
        chk($sformatf("R1 ok #%0d", e.tag), bnd_ok, e.ok);
        chk($sformatf("R2/R3/R4/R5/R6 map #%0d", e.tag), bnd_map, e.map);
        chk($sformatf("R7 dirty #%0d", e.tag), bnd_dirty, e.dirty);
        if (e.ok) begin
          chk($sformatf("R8 vfn #%0d", e.tag), bnd_vfn, e.vfn);
          chk($sformatf("R8 pfn #%0d", e.tag), bnd_pfn, e.pfn);
          chk($sformatf("R8 perm #%0d", e.tag), bnd_perm, e.perm);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", bnd_valid, 0);
    chk("R1 reset map", bnd_map, 0);
    rst_n = 1;
    idle(2);
    chk("R9 idle valid", bnd_valid, 0);

    // R2: fully contiguous line, group 4..7 only
    send(full_line(28'h100, 4'h5), 5, 30'h1234, 1);
    // R3: slot 2 frame shifted -> hole
    ln = full_line(28'h200, 4'h3); ln[2*64 +: 64] = mk(1, 1, 1, 1, 4'h3, 28'h2F0);
    send(ln, 1, 30'h0007, 2);
    // R4: slot 3 permission differs
    ln = full_line(28'h300, 4'h3); ln[3*64 +: 64] = mk(1, 1, 1, 1, 4'h7, 28'h303);
    send(ln, 0, 30'h0011, 3);
    // R5: slot 0 not accessed
    ln = full_line(28'h400, 4'h1); ln[0 +: 64] = mk(1, 0, 1, 1, 4'h1, 28'h400);
    send(ln, 2, 30'h0022, 4);
    // R6: slot 5 small page, slot 6 invalid
    ln = full_line(28'h500, 4'h2);
    ln[5*64 +: 64] = mk(1, 1, 1, 0, 4'h2, 28'h505);
    ln[6*64 +: 64] = mk(0, 1, 1, 1, 4'h2, 28'h506);
    send(ln, 7, 30'h0033, 5);
    idle(1);
    // R7: member not dirty clears flag
    ln = full_line(28'h600, 4'h4); ln[1*64 +: 64] = mk(1, 1, 0, 1, 4'h4, 28'h601);
    send(ln, 3, 30'h0044, 6);
    // R7: non-member (out of group) not dirty leaves flag set
    ln = full_line(28'h600, 4'h4); ln[4*64 +: 64] = mk(1, 1, 0, 1, 4'h4, 28'h604);
    send(ln, 3, 30'h0044, 7);
    // R1: requested slot invalid
    ln = full_line(28'h700, 4'h4); ln[6*64 +: 64] = mk(0, 1, 1, 1, 4'h4, 28'h706);
    send(ln, 6, 30'h0055, 8);
    // R1: requested slot small page
    ln = full_line(28'h800, 4'h4); ln[1*64 +: 64] = mk(1, 1, 1, 0, 4'h4, 28'h801);
    send(ln, 1, 30'h0066, 9);
    // R3: frame wraparound at top of range
    send(full_line(28'hFFFFFFE, 4'hA), 2, 30'h3FFFFFFF, 10);

    // mixed generated lines, back to back
    for (int n = 0; n < 40; n++) begin
      logic [27:0] f0;
      f0 = 28'($urandom);
      ln = full_line(f0, 4'(n));
      for (int i = 0; i < 8; i++) begin
        case ($urandom % 7)
          0: ln[i*64 + 1] = 1'b0;
          1: ln[i*64 + 2] = 1'b0;
          2: ln[i*64 + 4] = ~ln[i*64 + 4];
          3: ln[i*64 + 16] = ~ln[i*64 + 16];
          default: ;
        endcase
      end
      send(ln, n % 8, 30'($urandom), 8'(20 + n));
    end
    idle(3);
    // R9: no result while idle, fields held
    chk("R9 valid low after idle", bnd_valid, 0);
    chk("R9 map held", bnd_map, last_e.map);
    chk("R9 all results seen", q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule